// File: doc/BRIEF.md
# External Interrupt Pin Sense Unit

This unit watches one external interrupt pin and turns its activity into an interrupt flag, an interrupt request and a wake signal. A 2-bit sense setting chooses low level, falling edge or rising edge. Edge detection runs on the I/O clock through a synchronizer and a one-cycle history register. A matching transition sets a sticky flag that stays set until software clears it or the interrupt controller acknowledges it. Low-level sensing latches nothing. The request follows the synchronized pin for as long as it stays low. A wake output is also formed straight from the raw pin, so a low level can rouse a sleeping system while the I/O clock is halted.

The pin input carries the pad level whoever drives it. When the device's own output drives the pad, software can raise the interrupt by writing the pin. The `clk_run_i` input reports whether the I/O clock is running. While it is low, no edge is recognized. A low pulse that ends before the system finishes waking produces a wake pulse and nothing else, because nothing is latched in low-level mode.

Top module: `ext_irq_sense`

## Requirements
- R1: The sense code on `sense_i` means: 2'b00 low level, 2'b10 falling edge, 2'b11 rising edge. 2'b01 is reserved and never sets the flag and never raises the request or the wake signal.
- R2: While `rst_n` is low, `irq_flag_o` and `irq_req_o` are 0, and the synchronized pin state is taken as high.
- R3: In falling-edge mode, a high-to-low pin change that is stable before clock edge k is synchronized through 2 stages and sets `irq_flag_o` at edge k+2. A low-to-high change sets nothing.
- R4: In rising-edge mode, a low-to-high pin change that is stable before clock edge k sets `irq_flag_o` at edge k+2. A high-to-low change sets nothing.
- R5: Once set, the flag holds until a clock edge at which `flag_clr_i` or `irq_ack_i` is high, and then it clears. If a new edge is detected at that same clock edge, the set wins and the flag stays 1.
- R6: An edge is recognized only when `clk_run_i` is high at the clock edge where it is detected. Pin changes made while `clk_run_i` is low never set the flag, even after `clk_run_i` returns high.
- R7: In low-level mode, `irq_req_o` equals `irq_en_i` AND the 2-stage synchronized pin being low. It rises 2 clock edges after the pin falls, falls 2 edges after the pin rises, and the flag is never set in this mode.
- R8: `wake_o` is combinational from the raw pin: it is high exactly when `irq_en_i` is 1, `sense_i` is 2'b00 and `pin_i` is 0. No clock edge and no `clk_run_i` is needed.
- R9: A low `irq_en_i` forces `irq_req_o` and `wake_o` to 0 but does not stop the flag from being set. `irq_req_o` is `irq_en_i` AND (flag OR low-level condition).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw pad level of the interrupt pin |
| sense_i | input | 2 | Sense select: 00 low, 01 reserved, 10 falling, 11 rising |
| irq_en_i | input | 1 | Interrupt enable |
| clk_run_i | input | 1 | High while the I/O clock is running |
| flag_clr_i | input | 1 | Software clear strobe for the flag |
| irq_ack_i | input | 1 | Interrupt acknowledge, also clears the flag |
| irq_flag_o | output | 1 | Sticky edge flag |
| irq_req_o | output | 1 | Interrupt request to the controller |
| wake_o | output | 1 | Asynchronous low-level wake request |

## Verification
The bound checker checks these rules on every clock: the flag holds unless cleared, no flag appears while the clock is halted or in low-level or reserved mode, a disabled unit stays silent, and wake implies a low pin. Some behaviour shows only in the bench scenarios, where a behavioural model is compared with the outputs on each clock. These are the exact two-edge latency of edge and level detection, set winning over clear, the absence of a stale edge after a halt, and a sub-cycle low pulse that wakes the system but latches nothing.

// File: rtl/eis_pkg.sv
package eis_pkg;
  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_RSVD = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q[0] <= RESET_VAL;
    else        st_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[i] <= RESET_VAL;
      else        st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/eis_edge.sv
module eis_edge
  import eis_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sync_i,
  input  logic   clk_run_i,
  input  sense_e sense_i,
  output logic   hit_o
);
  logic prev_q;
  logic fall, rise, sel;

  // history register follows the synchronizer even while halted,
  // so a change made during a halt leaves no stale difference
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_i;
  end

  assign fall = prev_q & ~sync_i;
  assign rise = ~prev_q & sync_i;

  always_comb begin
    unique case (sense_i)
      SNS_FALL: sel = fall;
      SNS_RISE: sel = rise;
      default:  sel = 1'b0;
    endcase
  end

  assign hit_o = clk_run_i & sel;
endmodule

// File: rtl/eis_flag.sv
module eis_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eis_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] sense_i,
  input  logic       irq_en_i,
  input  logic       clk_run_i,
  input  logic       flag_clr_i,
  input  logic       irq_ack_i,
  output logic       irq_flag_o,
  output logic       irq_req_o,
  output logic       wake_o
);
  sense_e mode;
  logic   pin_sync;
  logic   edge_hit;
  logic   low_mode;
  logic   level_low;

  assign mode     = sense_e'(sense_i);
  assign low_mode = (mode == SNS_LOW);

  eis_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  eis_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_i    (pin_sync),
    .clk_run_i (clk_run_i),
    .sense_i   (mode),
    .hit_o     (edge_hit)
  );

  eis_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (edge_hit),
    .clr_i  (flag_clr_i | irq_ack_i),
    .flag_o (irq_flag_o)
  );

  assign level_low = low_mode & ~pin_sync;
  assign irq_req_o = irq_en_i & (irq_flag_o | level_low);
  // raw pin path: usable with the I/O clock stopped
  assign wake_o    = irq_en_i & low_mode & ~pin_i;
endmodule

// File: rtl/eis_checker.sv
module eis_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pin_i,
  input logic [1:0] sense_i,
  input logic       irq_en_i,
  input logic       clk_run_i,
  input logic       flag_clr_i,
  input logic       irq_ack_i,
  input logic       irq_flag_o,
  input logic       irq_req_o,
  input logic       wake_o
);
  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag_o && !flag_clr_i && !irq_ack_i) |=> irq_flag_o);

  // R6
  halt_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_run_i && !irq_flag_o) |=> !irq_flag_o);

  // R7
  level_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_i == 2'b00 && !irq_flag_o) |=> !irq_flag_o);

  // R1
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_i == 2'b01 && !irq_flag_o) |=> (!irq_flag_o && !wake_o));

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |-> (!irq_req_o && !wake_o));

  // R8
  wake_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (!pin_i && sense_i == 2'b00));
endmodule

bind ext_irq_sense eis_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pin_i      (pin_i),
  .sense_i    (sense_i),
  .irq_en_i   (irq_en_i),
  .clk_run_i  (clk_run_i),
  .flag_clr_i (flag_clr_i),
  .irq_ack_i  (irq_ack_i),
  .irq_flag_o (irq_flag_o),
  .irq_req_o  (irq_req_o),
  .wake_o     (wake_o)
);

// File: tb/ext_irq_sense_tb.sv
module ext_irq_sense_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin_i;
  logic [1:0] sense_i;
  logic       irq_en_i;
  logic       clk_run_i;
  logic       flag_clr_i;
  logic       irq_ack_i;
  logic       irq_flag_o;
  logic       irq_req_o;
  logic       wake_o;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_sense u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (pin_i),
    .sense_i    (sense_i),
    .irq_en_i   (irq_en_i),
    .clk_run_i  (clk_run_i),
    .flag_clr_i (flag_clr_i),
    .irq_ack_i  (irq_ack_i),
    .irq_flag_o (irq_flag_o),
    .irq_req_o  (irq_req_o),
    .wake_o     (wake_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: pin history queue and a sticky bit
  bit hist[$];
  bit m_prev;
  bit m_flag;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {1'b1, 1'b1};
      m_prev = 1'b1;
      m_flag = 1'b0;
    end else begin
      bit s;
      bit hit;
      s = hist[0];
      hit = 1'b0;
      if (clk_run_i && sense_i == 2'b10 && m_prev && !s) hit = 1'b1;
      if (clk_run_i && sense_i == 2'b11 && !m_prev && s) hit = 1'b1;
      if (hit) m_flag = 1'b1;
      else if (flag_clr_i || irq_ack_i) m_flag = 1'b0;
      m_prev = s;
      hist.push_back(pin_i);
      void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst_n === 1'b1 && hist.size() == 2) begin
      bit lvl;
      lvl = irq_en_i && sense_i == 2'b00 && !hist[0];
      chk("R3 R4 R5 model flag", irq_flag_o, m_flag);
      chk("R7 R9 model req", irq_req_o, (irq_en_i && m_flag) || lvl);
      chk("R8 model wake", wake_o, irq_en_i && sense_i == 2'b00 && !pin_i);
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #2;
    end
  endtask

  task automatic clear_flag();
    flag_clr_i = 1'b1;
    tick();
    flag_clr_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin_i = 1'b1; sense_i = 2'b10; irq_en_i = 1'b1;
    clk_run_i = 1'b1; flag_clr_i = 1'b0; irq_ack_i = 1'b0;
    tick(3);
    chk("R2 reset flag", irq_flag_o, 1'b0);
    chk("R2 reset req", irq_req_o, 1'b0);
    rst_n = 1'b1;
    tick(3);
    chk("R2 idle after reset", irq_flag_o, 1'b0);

    // falling edge latency
    pin_i = 1'b0;
    tick(); chk("R3 no flag at k", irq_flag_o, 1'b0);
    tick(); chk("R3 no flag at k+1", irq_flag_o, 1'b0);
    tick(); chk("R3 flag at k+2", irq_flag_o, 1'b1);
    chk("R9 req with flag", irq_req_o, 1'b1);
    clear_flag();
    chk("R5 clr strobe clears", irq_flag_o, 1'b0);
    pin_i = 1'b1;
    tick(4);
    chk("R3 rising ignored in fall mode", irq_flag_o, 1'b0);

    // rising edge latency and acknowledge
    sense_i = 2'b11;
    pin_i = 1'b0;
    tick(4);
    chk("R4 falling ignored in rise mode", irq_flag_o, 1'b0);
    pin_i = 1'b1;
    tick(2); chk("R4 no flag at k+1", irq_flag_o, 1'b0);
    tick(); chk("R4 flag at k+2", irq_flag_o, 1'b1);
    tick(3); chk("R5 flag holds", irq_flag_o, 1'b1);
    irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0;
    chk("R5 ack clears", irq_flag_o, 1'b0);

    // set beats clear at the same edge
    sense_i = 2'b10;
    flag_clr_i = 1'b1;
    pin_i = 1'b0;
    tick(3);
    chk("R5 set wins over clear", irq_flag_o, 1'b1);
    tick();
    flag_clr_i = 1'b0;
    chk("R5 clear after set", irq_flag_o, 1'b0);
    pin_i = 1'b1;
    tick(4);

    // halted clock: changes are lost
    clk_run_i = 1'b0;
    pin_i = 1'b0;
    tick(5);
    chk("R6 no edge while halted", irq_flag_o, 1'b0);
    clk_run_i = 1'b1;
    tick(5);
    chk("R6 no stale edge after resume", irq_flag_o, 1'b0);
    pin_i = 1'b1;
    tick(4);

    // low level mode
    sense_i = 2'b00;
    pin_i = 1'b0;
    #1;
    chk("R8 wake immediately", wake_o, 1'b1);
    tick(); chk("R7 req not yet at k", irq_req_o, 1'b0);
    tick(); chk("R7 req at k+1", irq_req_o, 1'b1);
    tick(4);
    chk("R7 req held while low", irq_req_o, 1'b1);
    chk("R7 no sticky flag", irq_flag_o, 1'b0);
    clk_run_i = 1'b0;
    tick(2);
    chk("R8 wake with clock halted", wake_o, 1'b1);
    chk("R7 level without clock", irq_req_o, 1'b1);
    clk_run_i = 1'b1;
    pin_i = 1'b1;
    tick(); chk("R7 req still at k", irq_req_o, 1'b1);
    tick(); chk("R7 req drops at k+1", irq_req_o, 1'b0);
    chk("R8 wake drops", wake_o, 1'b0);

    // short low pulse between edges: wake pulses, nothing latched
    @(negedge clk); #1;
    pin_i = 1'b0;
    #1; chk("R8 wake during short pulse", wake_o, 1'b1);
    #1; pin_i = 1'b1;
    tick(4);
    chk("R7 short pulse leaves no req", irq_req_o, 1'b0);
    chk("R7 short pulse leaves no flag", irq_flag_o, 1'b0);

    // reserved code
    sense_i = 2'b01;
    pin_i = 1'b0;
    #1; chk("R1 reserved no wake", wake_o, 1'b0);
    tick(4);
    pin_i = 1'b1;
    tick(4);
    chk("R1 reserved no flag", irq_flag_o, 1'b0);
    chk("R1 reserved no req", irq_req_o, 1'b0);

    // enable gating
    sense_i = 2'b10;
    irq_en_i = 1'b0;
    pin_i = 1'b0;
    tick(4);
    chk("R9 flag set while disabled", irq_flag_o, 1'b1);
    chk("R9 req gated", irq_req_o, 1'b0);
    irq_en_i = 1'b1;
    #1; chk("R9 req on enable", irq_req_o, 1'b1);
    clear_flag();
    sense_i = 2'b00;
    irq_en_i = 1'b0;
    tick(3);
    chk("R9 level req gated", irq_req_o, 1'b0);
    chk("R9 wake gated", wake_o, 1'b0);
    pin_i = 1'b1;
    tick(3);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule